// File: doc/BRIEF.md
# Wide Free-Running Tick Counter

This block keeps a 64-bit up-counter that software starts, preloads and reads over a plain 32-bit register bus. Once the start bit is set, the count goes up by one on every clock edge where the tick-enable input is high. The full value is also driven on an output port so that neighbouring logic, such as comparators, can use it directly.

Software loads the count one 32-bit word at a time. Each accepted word write sets its own sticky status flag, so the driver can confirm that the write took effect. The driver clears a flag by writing 1 to its bit position. The control register has a matching flag in a separate status register. Reads are combinational from the address. Writes take effect at the clock edge that samples them.

Top module: `wide_tick_counter`

## Requirements
- R1: After reset the count is zero, the start bit is clear and every status flag reads 0.
- R2: With the start bit (bit 8 of 0x240) set and `tick_en` high, the count rises by exactly one at each clock edge that carries no count-word write.
- R3: When the start bit is clear or `tick_en` is low, the count does not change.
- R4: A write to 0x100 loads the low word at the edge that samples it. The high word keeps its value and no increment happens at that edge.
- R5: A write to 0x104 loads the high word at the edge that samples it. The low word keeps its value and no increment happens at that edge.
- R6: An increment that rolls the low word over from all ones adds one to the high word at the same edge. An increment from all 64 bits set gives zero, and counting then continues.
- R7: The status register at 0x110 sets bit 0 at the edge that applies a low-word write and bit 1 at the edge that applies a high-word write. Each bit stays set afterwards.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Unused status bit positions read 0.
- R9: Bit 8 of the control register at 0x240 is the start bit. It reads back alone, and every other bit of that register reads 0.
- R10: Each control write sets bit 16 of the register at 0x24C. That bit clears on a write of 1 to it, and all other bits of that register read 0.
- R11: Any address other than the five listed reads 0. The `count_o` output equals the high and low word readbacks joined together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_en | input | 1 | Advance enable for the running count |
| count_o | output | 64 | Current 64-bit count |

## Verification
The bench loads a set of word patterns into each half of the count: zeros, all ones, alternating bits and walking values. Together these show whether the two words load independently and whether the status flags follow the right word. Runs with an irregular `tick_en` pattern, started just below a low-word rollover and just below the full 64-bit wrap, separate correct carry and wrap behaviour from a counter that only increments its low half. A write to a count word made while ticking shows that the load takes priority over the increment. A sweep over the whole address space with non-zero contents confirms that the decoder returns data only at the five mapped offsets.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  localparam int OFF_CNT_LO = 'h100;
  localparam int OFF_CNT_HI = 'h104;
  localparam int OFF_ST_CNT = 'h110;
  localparam int OFF_CTL    = 'h240;
  localparam int OFF_ST_CTL = 'h24C;
  localparam int START_BIT  = 8;
  localparam int ST_CTL_BIT = 16;
  localparam int NWORDS     = 2;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic st_cnt;
    logic ctl;
    logic st_ctl;
  } wtc_wr_t;
endpackage

// File: rtl/wtc_regif.sv
`timescale 1ns/1ps
module wtc_regif
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  input  logic [2*WORD_W-1:0] count,
  input  logic [1:0]          st_cnt,
  input  logic                start,
  input  logic                st_ctl,
  output wtc_wr_t             wr,
  output logic [WORD_W-1:0]   rdata
);
  logic hit_lo, hit_hi, hit_sc, hit_ctl, hit_sg;

  always_comb begin
    hit_lo  = (addr == ADDR_W'(OFF_CNT_LO));
    hit_hi  = (addr == ADDR_W'(OFF_CNT_HI));
    hit_sc  = (addr == ADDR_W'(OFF_ST_CNT));
    hit_ctl = (addr == ADDR_W'(OFF_CTL));
    hit_sg  = (addr == ADDR_W'(OFF_ST_CTL));
    wr.cnt_lo = we & hit_lo;
    wr.cnt_hi = we & hit_hi;
    wr.st_cnt = we & hit_sc;
    wr.ctl    = we & hit_ctl;
    wr.st_ctl = we & hit_sg;
  end

  always_comb begin
    rdata = '0;
    if (hit_lo)  rdata = count[WORD_W-1:0];
    if (hit_hi)  rdata = count[2*WORD_W-1:WORD_W];
    if (hit_sc)  rdata[1:0] = st_cnt;
    if (hit_ctl) rdata[START_BIT] = start;
    if (hit_sg)  rdata[ST_CTL_BIT] = st_ctl;
  end
endmodule

// File: rtl/wtc_count_core.sv
`timescale 1ns/1ps
module wtc_count_core
  import wtc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NWORDS-1:0]    ld,
  input  logic [WORD_W-1:0]    wdata,
  input  logic                 run,
  output logic [NWORDS*WORD_W-1:0] count
);
  localparam int CW = NWORDS * WORD_W;

  logic [CW-1:0] cnt_q, cnt_nxt, cnt_inc;
  logic          ld_any, cnt_en;

  assign ld_any  = |ld;
  assign cnt_en  = ld_any | run;
  assign cnt_inc = cnt_q + CW'(1);

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_comb begin
      if (ld[g])
        cnt_nxt[g*WORD_W +: WORD_W] = wdata;
      else if (ld_any)
        cnt_nxt[g*WORD_W +: WORD_W] = cnt_q[g*WORD_W +: WORD_W];
      else
        cnt_nxt[g*WORD_W +: WORD_W] = cnt_inc[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wtc_sticky.sv
`timescale 1ns/1ps
module wtc_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] q
);
  logic [N-1:0] q_r, q_nxt;
  logic         upd;

  assign upd = clr_en | (|set);

  always_comb begin
    q_nxt = q_r;
    if (clr_en) q_nxt = q_nxt & ~clr_mask;
    q_nxt = q_nxt | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/wide_tick_counter.sv
`timescale 1ns/1ps
module wide_tick_counter
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                tick_en,
  output logic [2*WORD_W-1:0] count_o
);
  logic [1:0]  rst_sync_q;
  logic        rst_n_s;
  wtc_wr_t     wr;
  logic        start_q;
  logic [1:0]  st_cnt_q;
  logic [0:0]  st_ctl_q;
  logic        unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wtc_regif #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regif (
    .addr(bus_addr), .we(bus_we), .count(count_o), .st_cnt(st_cnt_q),
    .start(start_q), .st_ctl(st_ctl_q[0]), .wr(wr), .rdata(bus_rdata)
  );

  wtc_count_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_n_s), .ld({wr.cnt_hi, wr.cnt_lo}),
    .wdata(bus_wdata), .run(start_q & tick_en), .count(count_o)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    start_q <= 1'b0;
    else if (wr.ctl) start_q <= bus_wdata[START_BIT];
  end

  wtc_sticky #(.N(2)) u_st_cnt (
    .clk(clk), .rst_n(rst_n_s), .set({wr.cnt_hi, wr.cnt_lo}),
    .clr_en(wr.st_cnt), .clr_mask(bus_wdata[1:0]), .q(st_cnt_q)
  );

  wtc_sticky #(.N(1)) u_st_ctl (
    .clk(clk), .rst_n(rst_n_s), .set(wr.ctl),
    .clr_en(wr.st_ctl), .clr_mask(bus_wdata[ST_CTL_BIT]), .q(st_ctl_q)
  );

  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/wtc_checker.sv
`timescale 1ns/1ps
module wtc_checker
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic                tick_en,
  input logic [2*WORD_W-1:0] count_o,
  input logic                start_q,
  input logic [1:0]          st_cnt_q
);
  logic wlo, whi, wsc;
  assign wlo = bus_we && bus_addr == ADDR_W'(OFF_CNT_LO);
  assign whi = bus_we && bus_addr == ADDR_W'(OFF_CNT_HI);
  assign wsc = bus_we && bus_addr == ADDR_W'(OFF_ST_CNT);

  // R2
  r2_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && tick_en && !wlo && !whi) |=> count_o == $past(count_o) + 1'b1);
  // R3
  r3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(start_q && tick_en) && !wlo && !whi) |=> $stable(count_o));
  // R4
  r4_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wlo |=> (count_o[WORD_W-1:0] == $past(bus_wdata)) &&
            (count_o[2*WORD_W-1:WORD_W] == $past(count_o[2*WORD_W-1:WORD_W])));
  // R5
  r5_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    whi |=> (count_o[2*WORD_W-1:WORD_W] == $past(bus_wdata)) &&
            (count_o[WORD_W-1:0] == $past(count_o[WORD_W-1:0])));
  // R7
  r7_lo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wlo |=> st_cnt_q[0]);
  // R8
  r8_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cnt_q[1] && !(wsc && bus_wdata[1])) |=> st_cnt_q[1]);
endmodule

bind wide_tick_counter wtc_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .tick_en(tick_en), .count_o(count_o),
  .start_q(start_q), .st_cnt_q(st_cnt_q)
);

// File: tb/sim_wide_tick_counter.sv
`timescale 1ns/1ps
module sim_wide_tick_counter;
  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_en;
  logic [63:0] count_o;

  int nchk;
  int nfail;
  bit done;

  wide_tick_counter u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .count_o(count_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, {32'h0, v}, {32'h0, exp});
  endtask

  function automatic bit mapped(input int a);
    return a == 'h100 || a == 'h104 || a == 'h110 || a == 'h240 || a == 'h24C;
  endfunction

  initial begin
    #600000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp;
    logic [31:0] pats [6];
    nchk = 0; nfail = 0; done = 0;
    bus_addr = '0; bus_we = 0; bus_wdata = '0; tick_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 count", count_o, 64'h0);
    rd_chk("R1 status", 12'h110, 32'h0);
    rd_chk("R1 ctl", 12'h240, 32'h0);
    rd_chk("R1 ctl status", 12'h24C, 32'h0);

    // R4 R5 R7 R11: word load patterns with tick_en low
    pats = '{32'h0, 32'hFFFFFFFF, 32'hAAAAAAAA, 32'h55555555, 32'h00010000, 32'h80000001};
    exp = 64'h0;
    foreach (pats[i]) begin
      wr(12'h100, pats[i]);
      exp[31:0] = pats[i];
      chk("R4 low load", count_o, exp);
      rd_chk("R7 low flag", 12'h110, 32'h1);
      wr(12'h104, ~pats[(i+1)%6]);
      exp[63:32] = ~pats[(i+1)%6];
      chk("R5 high load", count_o, exp);
      rd_chk("R11 low word read", 12'h100, exp[31:0]);
      rd_chk("R11 high word read", 12'h104, exp[63:32]);
      rd_chk("R7 both flags", 12'h110, 32'h3);
      // R8: writing 0 keeps, 1 clears
      wr(12'h110, 32'h0);
      rd_chk("R8 write zero keeps", 12'h110, 32'h3);
      wr(12'h110, 32'hFFFFFFFE);
      rd_chk("R8 clear bit1 only", 12'h110, 32'h1);
      wr(12'h110, 32'h1);
      rd_chk("R8 clear bit0", 12'h110, 32'h0);
      chk("R8 count untouched", count_o, exp);
    end

    // R9 R10: control readback and its flag
    wr(12'h240, 32'hFFFFFEFF);
    rd_chk("R9 start clear", 12'h240, 32'h0);
    rd_chk("R10 ctl flag", 12'h24C, 32'h00010000);
    wr(12'h24C, 32'hFFFEFFFF);
    rd_chk("R10 write zero keeps", 12'h24C, 32'h00010000);
    wr(12'h24C, 32'h00010000);
    rd_chk("R10 cleared", 12'h24C, 32'h0);

    // R3: ticking with start clear has no effect
    tick_en = 1;
    repeat (5) @(negedge clk);
    chk("R3 no start", count_o, exp);
    tick_en = 0;

    // R11: address sweep with non-zero contents
    wr(12'h100, 32'hC0DE1234);
    wr(12'h104, 32'h0BADF00D);
    exp = 64'h0BADF00D_C0DE1234;
    for (int a = 0; a < 4096; a += 4) begin
      logic [31:0] v;
      rd(12'(a), v);
      if (!mapped(a)) chk("R11 unmapped", {32'h0, v}, 64'h0);
    end
    chk("R11 count port", count_o, exp);

    // R2 R6: carry across low rollover, irregular ticks
    wr(12'h100, 32'hFFFFFFF0);
    wr(12'h104, 32'h00000007);
    exp = 64'h00000007_FFFFFFF0;
    wr(12'h240, 32'h100);
    rd_chk("R9 start set", 12'h240, 32'h100);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R2 R6 step", count_o, exp);
      tick_en = (i % 3 != 0);
      if (tick_en) exp = exp + 1;
    end
    @(negedge clk);
    tick_en = 0;
    chk("R6 carry", count_o, exp);
    rd_chk("R6 high word", 12'h104, 32'h8);

    // R3: tick_en low holds while started
    repeat (4) @(negedge clk);
    chk("R3 tick low", count_o, exp);

    // R6: full wrap
    wr(12'h100, 32'hFFFFFFFD);
    wr(12'h104, 32'hFFFFFFFF);
    exp = 64'hFFFFFFFF_FFFFFFFD;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R6 wrap", count_o, exp);
      tick_en = 1;
      exp = exp + 1;
    end
    @(negedge clk);
    chk("R6 after wrap", count_o, exp);

    // R4: load wins over increment while ticking
    bus_we = 1; bus_addr = 12'h100; bus_wdata = 32'h12345678;
    exp = {exp[63:32], 32'h12345678};
    @(negedge clk);
    bus_we = 0;
    chk("R4 load over tick", count_o, exp);
    exp = exp + 1;
    @(negedge clk);
    chk("R2 resumes", count_o, exp);
    // R5: same for high word
    bus_we = 1; bus_addr = 12'h104; bus_wdata = 32'hFFFFFFFF;
    exp = {32'hFFFFFFFF, exp[31:0]};
    @(negedge clk);
    bus_we = 0;
    tick_en = 0;
    chk("R5 load over tick", count_o, exp);

    // R3: stop via control
    wr(12'h240, 32'h0);
    tick_en = 1;
    repeat (4) @(negedge clk);
    chk("R3 stopped", count_o, exp);
    tick_en = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule